// File: doc/BRIEF.md
# Shared-Adder 4-Bit ALU

This block is a purely combinational arithmetic/logic unit for 4-bit operands. A 3-bit function code selects one of eight operations. Six of them are arithmetic: pass-through, two's-complement negation, increment, decrement, addition and subtraction. Two are bitwise logic: AND and XOR. Every arithmetic operation goes through one shared ripple-carry adder. Small selectors in front of that adder choose its two operands and its carry-in from the function code. The logic operations skip the adder and are picked up by a result selector at the output.

Alongside the 4-bit result the block drives four status flags: negative, signed overflow, zero and carry. For arithmetic codes the operands are read as two's-complement signed numbers. For logic codes they are read as plain bit vectors. The block holds no state, so its outputs follow its inputs with no clock edge involved. It is meant to sit in a datapath stage whose registers belong to the surrounding design.

Top module: `alu4_core`

## Requirements
- R1: Function code 000 (pass) drives the result with OPA. Carry and overflow are 0.
- R2: Function code 001 (negate) drives the result with (0 - OPA) mod 16. Carry is 1 only when OPA is 0000. Overflow is 1 only when OPA is 1000, and in that case the result is 1000.
- R3: Function code 010 (increment) drives the result with (OPA + 1) mod 16. Carry is 1 only when OPA is 1111. Overflow is 1 only when OPA is 0111.
- R4: Function code 011 (decrement) drives the result with (OPA - 1) mod 16. Carry is a no-borrow flag, so it is 0 only when OPA is 0000. Overflow is 1 only when OPA is 1000.
- R5: Function code 100 (add) drives the result with (OPA + OPB) mod 16. Carry is the unsigned carry-out. Overflow is 1 when the signed sum lies outside -8..7.
- R6: Function code 101 (subtract) drives the result with (OPA - OPB) mod 16. Carry is 1 exactly when OPA >= OPB unsigned, meaning no borrow. Overflow is 1 when the signed difference lies outside -8..7.
- R7: Function code 110 drives the result with the bitwise AND of OPA and OPB. Carry and overflow are forced to 0.
- R8: Function code 111 drives the result with the bitwise XOR of OPA and OPB. Carry and overflow are forced to 0.
- R9: For every function code, the negative flag equals result bit 3, and the zero flag is 1 exactly when the result is 0000.
- R10: The outputs hold no state. A change on any input shows up on the result and flags with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 4 | First operand |
| opb_i | input | 4 | Second operand |
| fsel_i | input | 3 | Function code, decoded as listed in the requirements |
| y_o | output | 4 | Result |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Signed overflow flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry / no-borrow flag |

## Verification
Since nothing is stored, a fault in the steering selectors, in a carry link of the adder or in the flag logic shows at the ports as soon as the inputs settle. It appears as a wrong result or flag for the very input pattern that exercises the faulty path. A broken carry link tends to appear only for operand pairs whose carries travel far enough to reach it. Swapping the carry-in of negate and decrement shows up on almost every operand. For that reason all 2048 combinations of function code and operands are compared against an independent reference. The comparison is preceded by a vector table that targets the carry and overflow boundaries.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    typedef enum logic [2:0] {
        FN_PASS = 3'b000,
        FN_NEG  = 3'b001,
        FN_INC  = 3'b010,
        FN_DEC  = 3'b011,
        FN_ADD  = 3'b100,
        FN_SUB  = 3'b101,
        FN_AND  = 3'b110,
        FN_XOR  = 3'b111
    } alu_fn_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } alu_flags_t;

endpackage

// File: rtl/alu4_steer.sv
module alu4_steer
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input  alu_fn_e        fn_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    output logic [W-1:0]   add_a_o,
    output logic [W-1:0]   add_b_o,
    output logic           add_cin_o
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ALL_ZERO = {W{1'b0}};

    // Operand A selector: only negate replaces OPA with zero.
    always_comb begin
        add_a_o = (fn_i == FN_NEG) ? ALL_ZERO : opa_i;
    end

    // Operand B selector and carry-in.
    always_comb begin
        add_b_o   = ALL_ZERO;
        add_cin_o = 1'b0;
        unique case (fn_i)
            FN_PASS: begin add_b_o = ALL_ZERO; add_cin_o = 1'b0; end
            FN_NEG:  begin add_b_o = ~opa_i;   add_cin_o = 1'b1; end
            FN_INC:  begin add_b_o = ALL_ZERO; add_cin_o = 1'b1; end
            FN_DEC:  begin add_b_o = ALL_ONES; add_cin_o = 1'b0; end
            FN_ADD:  begin add_b_o = opb_i;    add_cin_o = 1'b0; end
            FN_SUB:  begin add_b_o = ~opb_i;   add_cin_o = 1'b1; end
            default: begin add_b_o = ALL_ZERO; add_cin_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/alu4_ripple.sv
module alu4_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         c_msb_o,
    output logic         cout_o
);

    logic [W:0] carry_d;

    assign carry_d[0] = cin_i;

    for (genvar k = 0; k < W; k++) begin : g_fa
        assign sum_o[k]       = a_i[k] ^ b_i[k] ^ carry_d[k];
        assign carry_d[k + 1] = (a_i[k] & b_i[k]) | (carry_d[k] & (a_i[k] ^ b_i[k]));
    end

    assign c_msb_o = carry_d[W-1];
    assign cout_o  = carry_d[W];

    // R5: the bit-level chain must match a word-level sum.
    always_comb begin
        a_r5_chain_sum: assert ({cout_o, sum_o} ==
                                ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
            else $error("ripple chain disagrees with word sum");
    end

endmodule

// File: rtl/alu4_resmux.sv
module alu4_resmux
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input  alu_fn_e       fn_i,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    input  logic [W-1:0]  sum_i,
    input  logic          c_msb_i,
    input  logic          cout_i,
    output logic [W-1:0]  y_o,
    output alu_flags_t    flags_o
);

    logic is_logic_d;

    assign is_logic_d = (fn_i == FN_AND) || (fn_i == FN_XOR);

    always_comb begin
        unique case (fn_i)
            FN_AND:  y_o = opa_i & opb_i;
            FN_XOR:  y_o = opa_i ^ opb_i;
            default: y_o = sum_i;
        endcase
    end

    always_comb begin
        flags_o.n = y_o[W-1];
        flags_o.z = ~|y_o;
        flags_o.c = is_logic_d ? 1'b0 : cout_i;
        flags_o.v = is_logic_d ? 1'b0 : (c_msb_i ^ cout_i);
    end

endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [2:0]   fsel_i,
    output logic [W-1:0] y_o,
    output logic         n_o,
    output logic         v_o,
    output logic         z_o,
    output logic         c_o
);

    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    alu_fn_e    fn_d;
    logic [W-1:0] add_a_d;
    logic [W-1:0] add_b_d;
    logic         add_cin_d;
    logic [W-1:0] sum_d;
    logic         c_msb_d;
    logic         cout_d;
    alu_flags_t   flags_d;

    assign fn_d = alu_fn_e'(fsel_i);

    alu4_steer #(.W(W)) u_steer (
        .fn_i      (fn_d),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .add_a_o   (add_a_d),
        .add_b_o   (add_b_d),
        .add_cin_o (add_cin_d)
    );

    alu4_ripple #(.W(W)) u_adder (
        .a_i     (add_a_d),
        .b_i     (add_b_d),
        .cin_i   (add_cin_d),
        .sum_o   (sum_d),
        .c_msb_o (c_msb_d),
        .cout_o  (cout_d)
    );

    alu4_resmux #(.W(W)) u_resmux (
        .fn_i    (fn_d),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .sum_i   (sum_d),
        .c_msb_i (c_msb_d),
        .cout_i  (cout_d),
        .y_o     (y_o),
        .flags_o (flags_d)
    );

    assign n_o = flags_d.n;
    assign v_o = flags_d.v;
    assign z_o = flags_d.z;
    assign c_o = flags_d.c;

    // Port-level checks against word-level arithmetic.
    always_comb begin
        if (fn_d == FN_PASS) begin
            a_r1_pass: assert (y_o == opa_i && !c_o && !v_o)
                else $error("pass-through mismatch");
        end
        if (fn_d == FN_NEG) begin
            a_r2_neg_ovf: assert (v_o == (opa_i == MIN_NEG))
                else $error("negate overflow mismatch");
        end
        if (fn_d == FN_ADD) begin
            a_r5_add_sum: assert (y_o == W'(opa_i + opb_i))
                else $error("add result mismatch");
            a_r5_add_ovf: assert (v_o == ((opa_i[W-1] == opb_i[W-1]) &&
                                          (y_o[W-1] != opa_i[W-1])))
                else $error("add overflow mismatch");
        end
        if (fn_d == FN_SUB) begin
            a_r6_sub_borrow: assert (y_o == W'(opa_i - opb_i) && c_o == (opa_i >= opb_i))
                else $error("subtract result or borrow mismatch");
        end
        if (fn_d == FN_AND || fn_d == FN_XOR) begin
            a_r7_logic_flags: assert (!c_o && !v_o)
                else $error("logic op drove carry or overflow");
        end
    end

endmodule

// File: tb/sim_alu4_core.sv
module sim_alu4_core;

    logic       clk;
    logic [3:0] opa;
    logic [3:0] opb;
    logic [2:0] fsel;
    logic [3:0] y;
    logic       n, v, z, c;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // {fsel, opa, opb, y, n v z c}
    localparam logic [18:0] VEC [13] = '{
        {3'b000, 4'b0101, 4'b0000, 4'b0101, 4'b0000},
        {3'b001, 4'b1000, 4'b0000, 4'b1000, 4'b1100},
        {3'b001, 4'b0000, 4'b0000, 4'b0000, 4'b0011},
        {3'b010, 4'b0111, 4'b0000, 4'b1000, 4'b1100},
        {3'b010, 4'b1111, 4'b0000, 4'b0000, 4'b0011},
        {3'b011, 4'b0000, 4'b0000, 4'b1111, 4'b1000},
        {3'b011, 4'b1000, 4'b0000, 4'b0111, 4'b0101},
        {3'b100, 4'b0111, 4'b0001, 4'b1000, 4'b1100},
        {3'b100, 4'b1000, 4'b1000, 4'b0000, 4'b0111},
        {3'b101, 4'b0011, 4'b0101, 4'b1110, 4'b1000},
        {3'b101, 4'b1000, 4'b0001, 4'b0111, 4'b0101},
        {3'b110, 4'b1100, 4'b1010, 4'b1000, 4'b1000},
        {3'b111, 4'b1010, 4'b1010, 4'b0000, 4'b0010}
    };

    alu4_core u0 (
        .opa_i  (opa),
        .opb_i  (opb),
        .fsel_i (fsel),
        .y_o    (y),
        .n_o    (n),
        .v_o    (v),
        .z_o    (z),
        .c_o    (c)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic string req_of(input logic [2:0] f);
        case (f)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b011:  return "R4";
            3'b100:  return "R5";
            3'b101:  return "R6";
            3'b110:  return "R7";
            default: return "R8";
        endcase
    endfunction

    // Independent reference: returns {y, n, v, z, c}
    function automatic logic [7:0] model(input logic [2:0] f, input logic [3:0] a,
                                         input logic [3:0] b);
        int sa, sb, sr, ua, ub;
        logic [3:0] r;
        logic cv, vv;
        sa = $signed(a); sb = $signed(b);
        ua = int'(a);    ub = int'(b);
        sr = 0; cv = 0; vv = 0; r = '0;
        case (f)
            3'b000: begin sr = sa;      r = a;                cv = 0;          end
            3'b001: begin sr = -sa;     r = 4'(-ua);          cv = (a == 0);   end
            3'b010: begin sr = sa + 1;  r = 4'(ua + 1);       cv = (a == 15);  end
            3'b011: begin sr = sa - 1;  r = 4'(ua - 1);       cv = (a != 0);   end
            3'b100: begin sr = sa + sb; r = 4'(ua + ub);      cv = (ua + ub > 15); end
            3'b101: begin sr = sa - sb; r = 4'(ua - ub);      cv = (ua >= ub); end
            3'b110: begin r = a & b; end
            default: begin r = a ^ b; end
        endcase
        if (f[2:1] != 2'b11) vv = (sr > 7) || (sr < -8);
        return {r, r[3], vv, (r == 4'b0000), cv};
    endfunction

    task automatic compare(input string tag, input string what,
                           input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s fsel=%b opa=%b opb=%b actual=%b expected=%b",
                     tag, what, fsel, opa, opb, act, exp);
        end
    endtask

    task automatic check_all();
        logic [7:0] e;
        e = model(fsel, opa, opb);
        compare(req_of(fsel), "Y", y, e[7:4]);
        compare(req_of(fsel), "VC", {2'b00, v, c}, {2'b00, e[2], e[0]});
        compare("R9", "NZ", {2'b00, n, z}, {2'b00, e[3], e[1]});
    endtask

    initial begin
        opa = '0; opb = '0; fsel = '0;
        @(posedge clk); #1;
        // Idle state: all-zero inputs give zero result with only Z set (R1, R9)
        compare("R1", "idle Y", y, 4'b0000);
        compare("R9", "idle NVZC", {n, v, z, c}, 4'b0010);

        // Directed vector table: carry / overflow boundaries
        for (int i = 0; i < 13; i++) begin
            @(posedge clk);
            {fsel, opa, opb} = VEC[i][18:8];
            #1;
            compare(req_of(fsel), "table Y", y, VEC[i][7:4]);
            compare(req_of(fsel), "table NVZC", {n, v, z, c}, VEC[i][3:0]);
        end

        // Exhaustive sweep against the reference model
        for (int f = 0; f < 8; f++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    @(posedge clk);
                    fsel = 3'(f); opa = 4'(a); opb = 4'(b);
                    #1;
                    check_all();
                end
            end
        end

        // R10: outputs follow an input change between clock edges
        @(posedge clk);
        fsel = 3'b100; opa = 4'd3; opb = 4'd4;
        #1;
        compare("R10", "before change", y, 4'd7);
        opb = 4'd12;
        #0.5;
        compare("R10", "after change", y, 4'd15);
        compare("R10", "after change NVZC", {n, v, z, c}, 4'b1000);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired before the sweep completed");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule